// File: doc/BRIEF.md
# Microcoded Repeat-Counter Sequencer

This block sequences an arithmetic datapath from a microcode ROM. A start pulse first runs a load phase. In that phase the input operand words are written one by one into a dual-port register file, through port A, at addresses 0, 1, 2 and so on. The sequencer then fetches 31-bit microinstructions from a synchronous ROM, starting at address 0. Each instruction word holds four fields: a processing-element control word, a write enable and 6-bit address for each of the two register-file ports, and a repeat count.

The decoded fields drive registered outputs. An instruction whose count is c keeps those outputs for c+1 consecutive cycles, so one word can express a long run of identical operations, such as a chain of cubings. The next word is fetched while the current one repeats. The sequencer presents the next ROM address combinationally, so back-to-back instructions leave no empty cycle between them.

A reserved count value ends the program. It raises done for one cycle and returns the block to idle.

Top module: `ucode_seq`

## Requirements
- R1: While reset is high and right after it, done_o, ld_sel_o, a_wen_o, b_wen_o, both addresses and pe_ctrl_o are zero, and rom_addr_o is 0.
- R2: A start_i seen in idle begins a load phase of LOAD_WORDS cycles. Each of these cycles shows ld_sel_o=1 and a_wen_o=1, with a_addr_o stepping 0, 1, ..., LOAD_WORDS-1. In the same cycles b_wen_o is 0 and pe_ctrl_o is 0.
- R3: The instruction layout is: pe_ctrl in bits [30:20], port A write enable in bit 19, port A address in [18:13], port B write enable in bit 12, port B address in [11:6], repeat count in [5:0]. The word at ROM address 0 is driven on the outputs in the cycle that follows the last load cycle, and ld_sel_o is 0 from then on.
- R4: An instruction whose count is c keeps its decoded outputs for exactly c+1 consecutive cycles. A count of 0 executes once, and 62 executes 63 times.
- R5: Instructions run from consecutive ROM addresses. Each one appears in the cycle right after the final repeat of the one before it, with no idle cycle in between.
- R6: A word whose count field is all ones (63) ends the program. For that one cycle done_o is 1 and every write enable and pe_ctrl_o is 0, whatever the word's other fields hold. In the next cycle done_o is 0, the block is idle, and rom_addr_o is 0.
- R7: start_i has no effect while a load or a program is running.
- R8: If the word at address 0 is the end marker, done_o rises in the cycle right after the last load cycle, and no instruction outputs are ever shown.
- R9: Asserting reset in the middle of a run clears all outputs at once. A later start then runs the program again from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin load phase and program |
| done_o | output | 1 | One-cycle pulse at program end |
| rom_addr_o | output | 10 | Address of the next microword (synchronous ROM) |
| rom_data_i | input | 31 | Microword read from the ROM |
| ld_sel_o | output | 1 | Register-file port A data comes from the external operand |
| a_addr_o | output | 6 | Port A address |
| a_wen_o | output | 1 | Port A write enable |
| b_addr_o | output | 6 | Port B address |
| b_wen_o | output | 1 | Port B write enable |
| pe_ctrl_o | output | 11 | Processing-element control word |

## Verification
The bench runs a program whose counts include 0, 1, 3 and the largest legal value, 62. An off-by-one in the repeat counter would show up as a stretched or truncated instruction, and a missing prefetch would show up as an idle bubble. The end marker carries nonzero enables and control bits, which catch a design that lets those fields leak onto the outputs. One run places the end marker at address 0, and another raises start_i in mid-program to catch an unwanted restart. A reset in mid-run confirms that the next run starts cleanly from address 0 and does not resume from the old program counter.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;
  localparam int DEF_ROM_AW     = 10;
  localparam int DEF_CTRL_W     = 11;
  localparam int DEF_RF_AW      = 6;
  localparam int DEF_CNT_W      = 6;
  localparam int DEF_LOAD_WORDS = 6;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOAD = 2'd1,
    SQ_EXEC = 2'd2
  } sq_state_t;
endpackage

// File: rtl/ucode_seq_pc.sv
module ucode_seq_pc #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          clr,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] pc_nxt
);
  localparam logic [AW-1:0] STEP = 1;

  // Next address goes straight to the synchronous ROM, so the ROM data
  // always corresponds to pc_q after every edge.
  always_comb begin
    if (rst || clr)   pc_nxt = '0;
    else if (adv)     pc_nxt = pc_q + STEP;
    else              pc_nxt = pc_q;
  end

  always_ff @(posedge clk) begin
    pc_q <= pc_nxt;
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (pc_q == $past(pc_q) + STEP)); // R5
  AST_PC_REWIND: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pc_q == '0)); // R6
endmodule

// File: rtl/ucode_seq_rep.sv
module ucode_seq_rep #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  localparam logic [CW-1:0] ONE = 1;
  logic [CW-1:0] rep_q;

  always_ff @(posedge clk) begin
    if (rst)               rep_q <= '0;
    else if (load)         rep_q <= load_val;
    else if (rep_q != '0)  rep_q <= rep_q - ONE;
  end

  assign zero = (rep_q == '0);

  AST_REP_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (rep_q == $past(load_val))); // R4
  AST_REP_DEC: assert property (@(posedge clk) disable iff (rst)
    (!load && !zero) |=> (rep_q == $past(rep_q) - ONE)); // R4
endmodule

// File: rtl/ucode_seq_ldcnt.sv
module ucode_seq_ldcnt #(
  parameter int AW    = 6,
  parameter int WORDS = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  output logic [AW-1:0] idx,
  output logic          last
);
  localparam logic [AW-1:0] ONE      = 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)        idx <= '0;
    else if (en && !last)  idx <= idx + ONE;
  end

  assign last = (idx == LAST_IDX);

  AST_LD_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !last && !clr) |=> (idx == $past(idx) + ONE)); // R2
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_seq_pkg::*;
#(
  parameter int ROM_AW     = DEF_ROM_AW,
  parameter int CTRL_W     = DEF_CTRL_W,
  parameter int RF_AW      = DEF_RF_AW,
  parameter int CNT_W      = DEF_CNT_W,
  parameter int LOAD_WORDS = DEF_LOAD_WORDS,
  localparam int INSTR_W   = CTRL_W + 2 * (RF_AW + 1) + CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  output logic               done_o,
  output logic [ROM_AW-1:0]  rom_addr_o,
  input  logic [INSTR_W-1:0] rom_data_i,
  output logic               ld_sel_o,
  output logic [RF_AW-1:0]   a_addr_o,
  output logic               a_wen_o,
  output logic [RF_AW-1:0]   b_addr_o,
  output logic               b_wen_o,
  output logic [CTRL_W-1:0]  pe_ctrl_o
);
  // Field placement inside a microword (count at the bottom, control at the top)
  localparam int CNT_LSB  = 0;
  localparam int BA_LSB   = CNT_LSB + CNT_W;
  localparam int BW_BIT   = BA_LSB + RF_AW;
  localparam int AA_LSB   = BW_BIT + 1;
  localparam int AW_BIT   = AA_LSB + RF_AW;
  localparam int CTRL_LSB = AW_BIT + 1;
  localparam logic [RF_AW-1:0] ONE_A = 1;

  sq_state_t state;

  logic [CNT_W-1:0]  f_cnt;
  logic [RF_AW-1:0]  f_a_addr, f_b_addr;
  logic              f_a_wen, f_b_wen;
  logic [CTRL_W-1:0] f_ctrl;
  logic              is_end, issue, finish;
  logic              rep_zero, ld_last;
  logic [RF_AW-1:0]  ld_idx;
  logic [ROM_AW-1:0] pc_q;

  assign f_cnt    = rom_data_i[CNT_LSB +: CNT_W];
  assign f_b_addr = rom_data_i[BA_LSB +: RF_AW];
  assign f_b_wen  = rom_data_i[BW_BIT];
  assign f_a_addr = rom_data_i[AA_LSB +: RF_AW];
  assign f_a_wen  = rom_data_i[AW_BIT];
  assign f_ctrl   = rom_data_i[CTRL_LSB +: CTRL_W];

  assign is_end = &f_cnt;
  assign issue  = ((state == SQ_LOAD) && ld_last) || ((state == SQ_EXEC) && rep_zero);
  assign finish = issue && is_end;

  ucode_seq_pc #(.AW(ROM_AW)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .adv    (issue && !is_end),
    .clr    (finish),
    .pc_q   (pc_q),
    .pc_nxt (rom_addr_o)
  );

  ucode_seq_rep #(.CW(CNT_W)) u_rep (
    .clk      (clk),
    .rst      (rst),
    .load     (issue && !is_end),
    .load_val (f_cnt),
    .zero     (rep_zero)
  );

  ucode_seq_ldcnt #(.AW(RF_AW), .WORDS(LOAD_WORDS)) u_ld (
    .clk  (clk),
    .rst  (rst),
    .clr  (state == SQ_IDLE),
    .en   (state == SQ_LOAD),
    .idx  (ld_idx),
    .last (ld_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      done_o    <= 1'b0;
      ld_sel_o  <= 1'b0;
      a_addr_o  <= '0;
      a_wen_o   <= 1'b0;
      b_addr_o  <= '0;
      b_wen_o   <= 1'b0;
      pe_ctrl_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start_i) begin
            state     <= SQ_LOAD;
            ld_sel_o  <= 1'b1;
            a_wen_o   <= 1'b1;
            a_addr_o  <= '0;
            b_wen_o   <= 1'b0;
            b_addr_o  <= '0;
            pe_ctrl_o <= '0;
          end
        end
        SQ_LOAD: begin
          if (!ld_last) a_addr_o <= ld_idx + ONE_A;
        end
        default: ;
      endcase

      if (issue) begin
        ld_sel_o <= 1'b0;
        if (is_end) begin
          state     <= SQ_IDLE;
          done_o    <= 1'b1;
          a_addr_o  <= '0;
          a_wen_o   <= 1'b0;
          b_addr_o  <= '0;
          b_wen_o   <= 1'b0;
          pe_ctrl_o <= '0;
        end else begin
          state     <= SQ_EXEC;
          a_addr_o  <= f_a_addr;
          a_wen_o   <= f_a_wen;
          b_addr_o  <= f_b_addr;
          b_wen_o   <= f_b_wen;
          pe_ctrl_o <= f_ctrl;
        end
      end
    end
  end

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!a_wen_o && !b_wen_o && !ld_sel_o && pe_ctrl_o == '0)); // R6
  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_LOAD && !ld_last) |=>
      (ld_sel_o && a_wen_o && !b_wen_o && a_addr_o == $past(a_addr_o) + ONE_A)); // R2
  AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_EXEC && !rep_zero) |=>
      ($stable(pe_ctrl_o) && $stable(a_addr_o) && $stable(b_addr_o) &&
       $stable(a_wen_o) && $stable(b_wen_o))); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_EXEC && start_i && !issue) |=> (state == SQ_EXEC)); // R7
  AST_FIRST_FETCH: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_LOAD) |-> (pc_q == '0)); // R3
endmodule

// File: tb/ucode_seq_bench.sv
`timescale 1ns/1ps
module ucode_seq_bench;
  localparam int NPROG = 8;
  // Stimulus vectors: {ctrl[10:0], a_wen, a_addr[5:0], b_wen, b_addr[5:0], count[5:0]}
  localparam logic [30:0] PROG [NPROG] = '{
    {11'h123, 1'b1, 6'd6,  1'b0, 6'd1,  6'd0},
    {11'h7FF, 1'b0, 6'd63, 1'b1, 6'd2,  6'd3},
    {11'h055, 1'b1, 6'd10, 1'b1, 6'd11, 6'd0},
    {11'h2AA, 1'b0, 6'd0,  1'b0, 6'd5,  6'd0},
    {11'h400, 1'b1, 6'd33, 1'b0, 6'd7,  6'd62},
    {11'h001, 1'b1, 6'd1,  1'b1, 6'd1,  6'd1},
    {11'h3C3, 1'b1, 6'd21, 1'b1, 6'd42, 6'd63},
    {11'h111, 1'b1, 6'd9,  1'b1, 6'd9,  6'd0}
  };
  localparam logic [30:0] END_WORD = {11'h5A5, 1'b1, 6'd3, 1'b1, 6'd4, 6'd63};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        done_o, ld_sel_o, a_wen_o, b_wen_o;
  logic [9:0]  rom_addr_o;
  logic [30:0] rom_q;
  logic [5:0]  a_addr_o, b_addr_o;
  logic [10:0] pe_ctrl_o;
  logic [30:0] rom_img [16];
  logic [26:0] obs;
  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) rom_q <= rom_img[rom_addr_o[3:0]];

  ucode_seq u_ucode_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
    .rom_addr_o(rom_addr_o), .rom_data_i(rom_q), .ld_sel_o(ld_sel_o),
    .a_addr_o(a_addr_o), .a_wen_o(a_wen_o), .b_addr_o(b_addr_o),
    .b_wen_o(b_wen_o), .pe_ctrl_o(pe_ctrl_o)
  );

  assign obs = {done_o, ld_sel_o, a_wen_o, a_addr_o, b_wen_o, b_addr_o, pe_ctrl_o};

  function automatic logic [26:0] exp_instr(input logic [30:0] w);
    return {1'b0, 1'b0, w[19], w[18:13], w[12], w[11:6], w[30:20]};
  endfunction
  function automatic logic [26:0] exp_load(input int k);
    return {1'b0, 1'b1, 1'b1, 6'(k), 1'b0, 6'd0, 11'd0};
  endfunction
  localparam logic [26:0] EXP_IDLE = '0;
  localparam logic [26:0] EXP_DONE = {1'b1, 26'd0};

  task automatic check_out(input string tag, input logic [26:0] exp);
    n_vec++;
    if (obs !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, obs, exp);
    end
  endtask

  task automatic check_addr(input string tag, input logic [9:0] exp);
    n_vec++;
    if (rom_addr_o !== exp) begin
      n_bad++;
      $display("FAIL %s: rom_addr got %0d expected %0d", tag, rom_addr_o, exp);
    end
  endtask

  // One complete run from idle; poke raises start during instruction 1.
  task automatic do_run(input bit poke);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      check_out($sformatf("R2 load word %0d", k), exp_load(k));
      @(negedge clk);
    end
    for (int i = 0; i < NPROG; i++) begin
      logic [30:0] w;
      w = rom_img[i];
      if (&w[5:0]) break;
      for (int r = 0; r <= int'(w[5:0]); r++) begin
        start_i = (poke && i == 1);
        check_out($sformatf("R3 R4 R5 R7 instr %0d rep %0d", i, r), exp_instr(w));
        @(negedge clk);
      end
      start_i = 1'b0;
    end
    check_out("R6 R8 done pulse", EXP_DONE);
    @(negedge clk);
    check_out("R6 done low, idle", EXP_IDLE);
    check_addr("R6 rom address rewound", 10'd0);
    @(negedge clk);
    check_out("R7 no restart after done", EXP_IDLE);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < 16; j++) rom_img[j] = (j < NPROG) ? PROG[j] : '0;
    repeat (3) @(negedge clk);
    check_out("R1 outputs in reset", EXP_IDLE);
    check_addr("R1 rom address in reset", 10'd0);
    rst = 1'b0;
    @(negedge clk);
    check_out("R1 outputs after reset", EXP_IDLE);
    check_addr("R1 rom address after reset", 10'd0);

    do_run(1'b1);

    rom_img[0] = END_WORD;
    @(negedge clk);
    do_run(1'b0);
    rom_img[0] = PROG[0];
    @(negedge clk);

    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_out("R9 outputs cleared by reset", EXP_IDLE);
    rst = 1'b0;
    @(negedge clk);
    check_out("R9 idle after reset", EXP_IDLE);
    check_addr("R9 rom address after reset", 10'd0);
    do_run(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule